// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block serialises one byte plus a software-chosen ninth bit onto a single output line as an 11-bit asynchronous frame. The frame has a low start bit, the eight data bits least significant first, the ninth bit, and a high stop bit. Software starts a frame by writing the data buffer. The ninth bit is captured from a control input in the same cycle as that write, so it is often used to carry parity or an address marker.

Bit timing comes from a free-running divide-by-16 counter. That counter advances either on a prescaled system clock (every 2 or 4 clocks, so a bit lasts 32 or 64 clocks) or on an external baud-tick input that stands in for a programmable rate source. A frame does not start on the write itself. The start bit goes out a fixed five clocks after the first counter rollover that follows the write, and every later bit boundary keeps that same five-clock lag behind its rollover. A sticky completion flag is raised as the stop bit is placed on the line, and only a software clear removes it.

Top module: `nine_bit_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. After reset, `busy` and `done` are 0.
- R2: A frame is 11 bits in this order: a start bit of 0, `wr_byte[0]` through `wr_byte[7]`, the ninth bit, then a stop bit of 1.
- R3: The ninth bit is the value of `ninth_bit` in the cycle `wr_data` is accepted. Later changes to `ninth_bit` do not affect that frame.
- R4: `txd` falls to the start bit exactly 5 clocks after the clock edge that samples the first divide-by-16 rollover after the write. A rollover in the same cycle as the write does not count.
- R5: With `ext_mode`=0, every bit lasts 32 clocks when `baud_sel`=0 and 64 clocks when `baud_sel`=1.
- R6: `done` rises on the same clock edge that drives the stop bit onto `txd`, and not earlier.
- R7: Once set, `done` stays 1 until a cycle with `clr_done`=1. That cycle clears it, unless the stop bit is driven in the same cycle.
- R8: A `wr_data` pulse while `busy`=1 is ignored. The frame in progress is unchanged, and no second frame follows.
- R9: With `ext_mode`=1, the counter advances once per cycle with `ext_tick`=1, so a bit lasts 16 ticks.
- R10: `busy` is 1 from the edge after an accepted write until the end of the stop-bit period, one full bit time after the stop bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_sel | input | 1 | Prescale choice: 0 divides by 2, 1 divides by 4 |
| ext_mode | input | 1 | 1 selects `ext_tick` as the counter advance source |
| ext_tick | input | 1 | External one-cycle baud tick |
| wr_data | input | 1 | Data buffer write strobe |
| wr_byte | input | 8 | Byte to send |
| ninth_bit | input | 1 | Ninth bit value, captured on the write |
| clr_done | input | 1 | Software clear of the completion flag |
| txd | output | 1 | Serial output line |
| done | output | 1 | Sticky transmit-complete flag |
| busy | output | 1 | Frame pending or in progress |

## Verification
A wrong rollover count or lag stage shows up as a start edge that is off by whole clocks, and this is visible on `txd` within the first bit time. The external-tick test pins that edge to an exact cycle. A bad bit index or a bad capture register corrupts a mid-bit sample within one bit period of the fault. A bad flag or a bad state exit moves the `done` rise or the `busy` fall off their exact cycles relative to the start edge. A frame that restarts after a write is ignored shows up as `busy` or a low `txd` in the idle tail recorded after the frame.

// File: rtl/ntx_pkg.sv
// Shared types for the nine-bit serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package ntx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,   // line high, waiting for a buffer write
        TX_ARMED = 2'd1,   // write taken, waiting for the next rollover
        TX_LAG   = 2'd2,   // rollover seen, waiting out the fixed lag
        TX_SEND  = 2'd3    // shifting frame bits
    } tx_state_e;
endpackage

// File: rtl/ntx_rate.sv
// Produces the advance enable for the divide-by-16 counter.
// Assumes: PS_FAST and PS_SLOW >= 2; ext_tick is a one-cycle pulse.
module ntx_rate #(
    parameter int PS_FAST = 2,
    parameter int PS_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_sel,
    input  logic ext_mode,
    input  logic ext_tick,
    output logic adv_en
);
    localparam int CW = (PS_SLOW > 1) ? $clog2(PS_SLOW) : 1;
    localparam logic [CW-1:0] LIM_FAST = CW'(PS_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(PS_SLOW - 1);

    logic [CW-1:0] pre_cnt;
    logic [CW-1:0] pre_lim;
    logic          pre_hit;

    assign pre_lim = baud_sel ? LIM_SLOW : LIM_FAST;
    assign pre_hit = (pre_cnt >= pre_lim);
    assign adv_en  = ext_mode ? ext_tick : pre_hit;

    // Free-running prescale counter, wraps at the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (pre_hit) pre_cnt <= '0;
        else              pre_cnt <= pre_cnt + 1'b1;
    end

    // A prescaled enable never repeats on back-to-back cycles.
    assert_prescale_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && adv_en) |=> (ext_mode || !adv_en));
endmodule

// File: rtl/ntx_bitclk.sv
// Divide-by-OVERSAMPLE counter giving a rollover pulse, plus a fixed
// START_LAG-clock delay line that turns each rollover into a shift strobe.
// Assumes: rollovers are spaced more than START_LAG clocks apart.
module ntx_bitclk #(
    parameter int OVERSAMPLE = 16,
    parameter int START_LAG  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    output logic roll,
    output logic strobe
);
    localparam int DW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [DW-1:0] LAST = DW'(OVERSAMPLE - 1);

    logic [DW-1:0] div_cnt;

    assign roll = adv_en && (div_cnt == LAST);

    // Advance the divider on each enable and wrap after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_cnt <= '0;
        else if (roll)   div_cnt <= '0;
        else if (adv_en) div_cnt <= div_cnt + 1'b1;
    end

    generate
        if (START_LAG <= 1) begin : g_lag1
            logic lag_q;
            // Single-stage delay of the rollover pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) lag_q <= 1'b0;
                else        lag_q <= roll;
            end
            assign strobe = lag_q;
        end else begin : g_lagn
            logic [START_LAG-1:0] lag_q;
            // Multi-stage delay line of the rollover pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) lag_q <= '0;
                else        lag_q <= {lag_q[START_LAG-2:0], roll};
            end
            assign strobe = lag_q[START_LAG-1];
        end
    endgenerate
endmodule

// File: rtl/ntx_shifter.sv
// Frame sequencer: captures byte and ninth bit on a write, arms on the next
// rollover, starts on the delayed strobe and shifts one bit per strobe.
// Assumes: strobe is a one-cycle pulse that lags roll by a fixed delay.
module ntx_shifter
    import ntx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              ninth_bit,
    input  logic              clr_done,
    input  logic              roll,
    input  logic              strobe,
    output logic              txd,
    output logic              done,
    output logic              busy
);
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] STOP_IDX = IW'(FRAME_BITS - 1);

    tx_state_e             state_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic [IW-1:0]         idx_q;
    logic [IW-1:0]         idx_nx;
    logic                  txd_q;
    logic                  done_q;
    logic                  set_done;

    assign idx_nx   = idx_q + 1'b1;
    assign set_done = (state_q == TX_SEND) && strobe && (idx_nx == STOP_IDX);
    assign txd  = txd_q;
    assign done = done_q;
    assign busy = (state_q != TX_IDLE);

    // Sequence the frame: capture, arm, lag, then shift bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            frame_q <= '1;
            idx_q   <= '0;
            txd_q   <= 1'b1;
        end else begin
            case (state_q)
                TX_IDLE: if (wr_data) begin
                    frame_q <= {1'b1, ninth_bit, wr_byte, 1'b0};
                    state_q <= TX_ARMED;
                end
                TX_ARMED: if (roll) state_q <= TX_LAG;
                TX_LAG: if (strobe) begin
                    state_q <= TX_SEND;
                    idx_q   <= '0;
                    txd_q   <= frame_q[0];
                end
                TX_SEND: if (strobe) begin
                    if (idx_q == STOP_IDX) begin
                        state_q <= TX_IDLE;
                        txd_q   <= 1'b1;
                    end else begin
                        idx_q <= idx_nx;
                        txd_q <= frame_q[idx_nx];
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Sticky completion flag: set as the stop bit goes out, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (set_done) done_q <= 1'b1;
        else if (clr_done) done_q <= 1'b0;
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> txd_q);
    assert_start_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_q) |-> $past(strobe));
    assert_done_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (txd_q && idx_q == STOP_IDX));
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_done) |=> done_q);
    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE && wr_data) |=> $stable(frame_q));
endmodule

// File: rtl/nine_bit_tx.sv
// Top of the nine-bit asynchronous transmitter: rate select, bit clock and
// frame sequencer.
// Assumes: synchronous active-low reset; one write per frame.
module nine_bit_tx #(
    parameter int DATA_W     = 8,
    parameter int PS_FAST    = 2,
    parameter int PS_SLOW    = 4,
    parameter int OVERSAMPLE = 16,
    parameter int START_LAG  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_sel,
    input  logic              ext_mode,
    input  logic              ext_tick,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              ninth_bit,
    input  logic              clr_done,
    output logic              txd,
    output logic              done,
    output logic              busy
);
    logic adv_en;
    logic roll;
    logic strobe;

    ntx_rate #(.PS_FAST(PS_FAST), .PS_SLOW(PS_SLOW)) u_rate (
        .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .ext_mode(ext_mode),
        .ext_tick(ext_tick), .adv_en(adv_en)
    );

    ntx_bitclk #(.OVERSAMPLE(OVERSAMPLE), .START_LAG(START_LAG)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .roll(roll), .strobe(strobe)
    );

    ntx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_byte(wr_byte),
        .ninth_bit(ninth_bit), .clr_done(clr_done), .roll(roll),
        .strobe(strobe), .txd(txd), .done(done), .busy(busy)
    );
endmodule

// File: tb/nine_bit_tx_test.sv
// Directed bench for the nine-bit transmitter: each task drives one scenario
// and checks its own results at negative clock edges.
module nine_bit_tx_test;
    localparam int CLK_NS = 10;
    localparam int HMAX   = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_sel = 1'b0;
    logic       ext_mode = 1'b0;
    logic       ext_tick = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       ninth_bit = 1'b0;
    logic       clr_done = 1'b0;
    logic       txd, done, busy;

    int total = 0;
    int bad = 0;
    logic h_txd [HMAX];
    logic h_done[HMAX];
    logic h_busy[HMAX];

    nine_bit_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .ext_mode(ext_mode),
        .ext_tick(ext_tick), .wr_data(wr_data), .wr_byte(wr_byte),
        .ninth_bit(ninth_bit), .clr_done(clr_done), .txd(txd), .done(done),
        .busy(busy)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; ext_mode = mode; ext_tick = 1'b0; wr_data = 1'b0; clr_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] b, input logic nb);
        @(negedge clk);
        wr_data = 1'b1; wr_byte = b; ninth_bit = nb;
        @(negedge clk);
        wr_data = 1'b0;
        // R10: busy is set on the edge after the write
        chk(busy === 1'b1, "R10 busy after write", int'(busy), 1);
    endtask

    // Record n cycles of outputs; optional ticks and one mid-frame write.
    task automatic record(input int n, input logic ticks, input int mid_wr);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            h_txd[c] = txd; h_done[c] = done; h_busy[c] = busy;
            ext_tick = ticks && (c % 2 == 0);
            wr_data  = (c == mid_wr);
            if (c == mid_wr) wr_byte = 8'hFF;
        end
        @(negedge clk);
        ext_tick = 1'b0; wr_data = 1'b0;
    endtask

    // Check one recorded frame; returns start index through t0.
    task automatic check_frame(input int n, input int p, input logic [7:0] b,
                               input logic nb, output int t0);
        logic [10:0] exp_f;
        exp_f = {1'b1, nb, b, 1'b0};
        t0 = -1;
        chk(h_txd[0] === 1'b1, "R1 line high before start", int'(h_txd[0]), 1);
        for (int c = 0; c < n; c++) if (t0 < 0 && h_txd[c] === 1'b0) t0 = c;
        chk(t0 >= 0 && t0 + 11*p + 8 < n, "R2 frame seen", t0, 0);
        if (t0 < 0 || t0 + 11*p + 8 >= n) return;
        for (int k = 0; k < 11; k++)
            chk(h_txd[t0 + k*p + p/2] === exp_f[k], $sformatf("R2 R3 bit %0d", k),
                int'(h_txd[t0 + k*p + p/2]), int'(exp_f[k]));
        chk(h_txd[t0 + p - 1] === 1'b0 && h_txd[t0 + p] === exp_f[1],
            "R5 R9 start bit length", int'(h_txd[t0 + p - 1]), 0);
        chk(h_done[t0 + 10*p - 1] === 1'b0, "R6 done not early", int'(h_done[t0 + 10*p - 1]), 0);
        chk(h_done[t0 + 10*p] === 1'b1, "R6 done with stop", int'(h_done[t0 + 10*p]), 1);
        chk(h_busy[t0 + 11*p - 1] === 1'b1, "R10 busy through stop", int'(h_busy[t0 + 11*p - 1]), 1);
        chk(h_busy[t0 + 11*p] === 1'b0, "R10 busy drops", int'(h_busy[t0 + 11*p]), 0);
        for (int c = t0 + 11*p; c < n; c++)
            if (h_txd[c] !== 1'b1 || h_busy[c] !== 1'b0) begin
                chk(1'b0, "R1 R8 idle after frame", c, -1);
                break;
            end
    endtask

    task automatic test_reset();
        do_reset(1'b0);
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd reset", int'(txd), 1);
        chk(busy === 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done === 1'b0, "R1 done reset", int'(done), 0);
    endtask

    task automatic test_fast_frame();
        int t0;
        baud_sel = 1'b0;
        do_write(8'hA5, 1'b1);
        ninth_bit = 1'b0;   // R3: must not reach the frame
        record(460, 1'b0, -1);
        check_frame(460, 32, 8'hA5, 1'b1, t0);
    endtask

    task automatic test_done_clear();
        repeat (20) @(negedge clk);
        chk(done === 1'b1, "R7 done held", int'(done), 1);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        chk(done === 1'b0, "R7 done cleared", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(done === 1'b0, "R7 stays clear", int'(done), 0);
    endtask

    task automatic test_slow_busy_write();
        int t0;
        baud_sel = 1'b1;
        do_write(8'h3C, 1'b0);
        record(900, 1'b0, 200);   // R8: write of 0xFF mid-frame
        check_frame(900, 64, 8'h3C, 1'b0, t0);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
    endtask

    task automatic test_ext_ticks();
        int t0;
        do_reset(1'b1);
        baud_sel = 1'b1;
        do_write(8'h81, 1'b1);
        record(420, 1'b1, -1);
        // 16th tick driven at recorded cycle 30; start visible 6 negedges later
        chk(h_txd[35] === 1'b1, "R4 not before lag", int'(h_txd[35]), 1);
        chk(h_txd[36] === 1'b0, "R4 start after lag", int'(h_txd[36]), 0);
        check_frame(420, 32, 8'h81, 1'b1, t0);
        chk(t0 == 36, "R4 R9 start index", t0, 36);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_fast_frame();
        test_done_clear();
        test_slow_busy_write();
        test_ext_ticks();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule